// File: doc/BRIEF.md
# Condition-Field Two-Input Lookup Unit

This unit holds a 32-bit condition register split into eight 4-bit fields and executes one kind of instruction on it: a per-bit two-input lookup whose truth table is taken from a register field at run time rather than from an immediate. Each instruction word names three fields: a destination, an index field and a table field. It also carries a 4-bit write mask. For each bit position i of a field, the destination's bit i is the high index bit and the index field's bit i is the low index bit. Together they select one of the four entries of the table field. The entry lands in the destination's bit i only where the mask allows.

Instructions arrive on a valid/ready handshake at one per cycle, and each result can be seen on the next cycle. Fetch, opcode decoding and vector repetition are handled elsewhere, so the opcode fields of the word play no part here. Words with nonzero reserved bits are refused with a one-cycle illegal-instruction flag. A test port shows the whole register and can also load it in a single cycle, so that a test can seed any register content.

A small controller tracks the outcome of the last cycle in four states: `ST_IDLE` (nothing happened), `ST_EXEC` (an instruction was written back), `ST_TRAP` (an instruction was refused) and `ST_LOAD` (the test port loaded the register). Every state can move to every other state, and the move depends only on that cycle's inputs. Reset or no activity goes to `ST_IDLE`. An active load goes to `ST_LOAD`. An accepted legal word goes to `ST_EXEC`. An accepted word with reserved bits set goes to `ST_TRAP`.

Top module: `crlut_unit`

## Requirements
- R1: A synchronous reset clears every bit of `cr_view` to 0 and drops `illegal`. `in_ready` is low while `rst` is high.
- R2: For bit position i (0 to 3) of a field, the index is j = 2*dst[i] + idx[i]. The selected table entry is bit j of the table field. Bit numbering inside a field runs MSB-first, so entry 0 is the field's most significant bit.
- R3: Where mask bit i is 1, destination bit i becomes table entry j. Where it is 0, that bit keeps its value. A zero mask leaves `cr_view` unchanged.
- R4: Field n occupies `cr_view[31-4n : 28-4n]`. Bit i of field n is `cr_view[31-4n-i]`. Fields other than the destination never change on an instruction.
- R5: Word fields, counting `in_word[31]` as instruction bit 0: destination selector `in_word[25:23]`, index selector `in_word[20:18]`, table selector `in_word[15:13]`. Mask bits 0, 1, 2 and 3 are `in_word[22]`, `in_word[21]`, `in_word[17]` and `in_word[16]`.
- R6: All three fields are read before the write, so the table or index selector may equal the destination selector.
- R7: If any reserved bit (`in_word[12:6]` or `in_word[0]`) is 1, the accepted word writes nothing. `illegal` is then 1 for exactly the following cycle.
- R8: Outside reset and load, `in_ready` is 1. Words can be accepted on back-to-back cycles, and each result is visible on `cr_view` one cycle after acceptance.
- R9: The opcode bits `in_word[31:26]` and `in_word[5:1]` have no effect on the result.
- R10: While `in_valid` and `cr_load` are both low, `cr_view` holds its value.
- R11: When `cr_load` is 1, `in_ready` is 0 and `cr_view` equals `cr_load_data` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 32 | Instruction word |
| cr_load | input | 1 | Test-port load strobe |
| cr_load_data | input | 32 | Value to load into the register |
| illegal | output | 1 | Previous accepted word had reserved bits set |
| cr_view | output | 32 | Current condition register contents |

## Verification
The lookup is swept over every combination of destination, index and table selector and every mask value. A fresh pseudo-random register is loaded before each word, so all four table entries and all four index values come up at every bit position, including the cases where selectors coincide. This separates errors in index order, table bit order, masking and read-before-write aliasing. Random opcode bits ride along with each word, so any dependence on them shows up as a mismatch. Bursts of words on consecutive cycles check the one-cycle turnaround. Each reserved bit is then set on its own to show that it alone blocks the write and raises the flag for exactly one cycle. Idle cycles with junk on the word bus confirm that nothing moves without a valid word.

// File: rtl/crlut_pkg.sv
`timescale 1ns/1ps
package crlut_pkg;
    // register geometry: the two-input table needs exactly four entries
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int CR_W       = FIELD_W * NUM_FIELDS;
    localparam int WORD_W     = 32;

    // instruction positions, counted from the word's MSB as bit 0
    localparam int P_DST      = 6;
    localparam int P_MASK01   = 9;
    localparam int P_IDX      = 11;
    localparam int P_MASK23   = 14;
    localparam int P_TBL      = 16;
    localparam int P_RSV_LO   = 19;
    localparam int P_RSV_HI   = 25;
    localparam int P_RSV_LAST = 31;

    // convert an MSB-first position into a vector index
    localparam int I_DST    = WORD_W - 1 - P_DST;
    localparam int I_IDX    = WORD_W - 1 - P_IDX;
    localparam int I_TBL    = WORD_W - 1 - P_TBL;
    localparam int I_M01    = WORD_W - 1 - P_MASK01;
    localparam int I_M23    = WORD_W - 1 - P_MASK23;
    localparam int I_RSV_T  = WORD_W - 1 - P_RSV_LO;
    localparam int I_RSV_B  = WORD_W - 1 - P_RSV_HI;
    localparam int I_RSV_L  = WORD_W - 1 - P_RSV_LAST;

    typedef logic [SEL_W-1:0]   fsel_t;
    // nibble convention: element [FIELD_W-1-i] holds field bit i
    typedef logic [FIELD_W-1:0] nib_t;

    typedef struct packed {
        fsel_t dst;
        fsel_t idx;
        fsel_t tbl;
        nib_t  mask;
        logic  bad;
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_TRAP = 2'd2,
        ST_LOAD = 2'd3
    } state_t;
endpackage

// File: rtl/crlut_decode.sv
`timescale 1ns/1ps
module crlut_decode
    import crlut_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output op_t               op
);
    // opcode bits belong to the upstream decoder
    logic [10:0] opcode_bits_unused;
    assign opcode_bits_unused = {word[WORD_W-1 -: 6], word[5:1]};

    always_comb begin
        op.dst  = word[I_DST -: SEL_W];
        op.idx  = word[I_IDX -: SEL_W];
        op.tbl  = word[I_TBL -: SEL_W];
        // mask nibble uses the same MSB-first layout as a field
        op.mask = {word[I_M01], word[I_M01-1], word[I_M23], word[I_M23-1]};
        op.bad  = (|word[I_RSV_T:I_RSV_B]) | word[I_RSV_L];
    end
endmodule

// File: rtl/crlut_crfile.sv
`timescale 1ns/1ps
module crlut_crfile
    import crlut_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic [CR_W-1:0] load_data,
    input  logic            wr_en,
    input  fsel_t           wr_sel,
    input  nib_t            wr_data,
    input  fsel_t           rd_sel_a,
    input  fsel_t           rd_sel_b,
    input  fsel_t           rd_sel_c,
    output nib_t            rd_a,
    output nib_t            rd_b,
    output nib_t            rd_c,
    output logic [CR_W-1:0] flat
);
    nib_t fields [NUM_FIELDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_FIELDS; n++) fields[n] <= '0;
        end else if (load_en) begin
            for (int n = 0; n < NUM_FIELDS; n++)
                fields[n] <= load_data[CR_W-1-n*FIELD_W -: FIELD_W];
        end else if (wr_en) begin
            fields[wr_sel] <= wr_data;
        end
    end

    // reads see the pre-write contents
    assign rd_a = fields[rd_sel_a];
    assign rd_b = fields[rd_sel_b];
    assign rd_c = fields[rd_sel_c];

    // field 0 sits at the top of the flat view
    for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_flat
        assign flat[CR_W-1-n*FIELD_W -: FIELD_W] = fields[n];
    end
endmodule

// File: rtl/crlut_lanes.sv
`timescale 1ns/1ps
module crlut_lanes
    import crlut_pkg::*;
(
    input  nib_t dst_val,
    input  nib_t idx_val,
    input  nib_t tbl_val,
    input  nib_t mask,
    output nib_t result
);
    for (genvar i = 0; i < FIELD_W; i++) begin : g_lane
        logic [1:0] sel;
        logic       entry;
        assign sel = {dst_val[FIELD_W-1-i], idx_val[FIELD_W-1-i]};
        // entry j sits at nibble index 3-j, which is the bitwise inverse of j
        assign entry = tbl_val[~sel];
        assign result[FIELD_W-1-i] = mask[FIELD_W-1-i] ? entry : dst_val[FIELD_W-1-i];
    end
endmodule

// File: rtl/crlut_ctrl.sv
`timescale 1ns/1ps
module crlut_ctrl
    import crlut_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  logic in_valid,
    input  logic bad,
    output logic in_ready,
    output logic wr_en,
    output logic illegal
);
    state_t state, state_nx;
    logic   take;

    assign take = in_valid && in_ready;

    always_comb begin
        state_nx = ST_IDLE;
        if (load_en)   state_nx = ST_LOAD;
        else if (take) state_nx = bad ? ST_TRAP : ST_EXEC;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        in_ready = !rst && !load_en;
        wr_en    = take && !bad;
        illegal  = 1'b0;
        unique case (state)
            ST_IDLE: illegal = 1'b0;
            ST_EXEC: illegal = 1'b0;
            ST_TRAP: illegal = 1'b1;
            ST_LOAD: illegal = 1'b0;
            default: illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/crlut_unit.sv
`timescale 1ns/1ps
module crlut_unit
    import crlut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cr_load,
    input  logic [CR_W-1:0]   cr_load_data,
    output logic              illegal,
    output logic [CR_W-1:0]   cr_view
);
    op_t  op;
    nib_t dst_val, idx_val, tbl_val, result;
    logic wr_en;

    crlut_decode u_dec (
        .word (in_word),
        .op   (op)
    );

    crlut_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_en  (cr_load),
        .in_valid (in_valid),
        .bad      (op.bad),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .illegal  (illegal)
    );

    crlut_crfile u_cr (
        .clk       (clk),
        .rst       (rst),
        .load_en   (cr_load),
        .load_data (cr_load_data),
        .wr_en     (wr_en),
        .wr_sel    (op.dst),
        .wr_data   (result),
        .rd_sel_a  (op.dst),
        .rd_sel_b  (op.idx),
        .rd_sel_c  (op.tbl),
        .rd_a      (dst_val),
        .rd_b      (idx_val),
        .rd_c      (tbl_val),
        .flat      (cr_view)
    );

    crlut_lanes u_lanes (
        .dst_val (dst_val),
        .idx_val (idx_val),
        .tbl_val (tbl_val),
        .mask    (op.mask),
        .result  (result)
    );
endmodule

// File: rtl/crlut_chk.sv
`timescale 1ns/1ps
module crlut_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  rsv_bits,
    input logic [3:0]  mask_bits,
    input logic        cr_load,
    input logic [31:0] cr_load_data,
    input logic        illegal,
    input logic [31:0] cr_view
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cr_view == 32'h0 && !illegal));

    // R8
    ready_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        !cr_load |-> in_ready);

    // R11
    load_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        cr_load |-> !in_ready);

    // R11
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        cr_load |=> (cr_view == $past(cr_load_data)));

    // R7
    reserved_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (|rsv_bits)) |=> (illegal && $stable(cr_view)));

    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $past(in_valid && in_ready && (|rsv_bits)));

    // R3
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && rsv_bits == 8'h0 && mask_bits == 4'h0) |=> $stable(cr_view));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !cr_load) |=> $stable(cr_view));
endmodule

bind crlut_unit crlut_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .rsv_bits     ({in_word[12:6], in_word[0]}),
    .mask_bits    ({in_word[22], in_word[21], in_word[17], in_word[16]}),
    .cr_load      (cr_load),
    .cr_load_data (cr_load_data),
    .illegal      (illegal),
    .cr_view      (cr_view)
);

// File: tb/crlut_unit_test.sv
`timescale 1ns/1ps
module crlut_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        cr_load;
    logic [31:0] cr_load_data;
    logic        illegal;
    logic [31:0] cr_view;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1bad_5eed;
    logic [31:0] exp_cr;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crlut_unit uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_word      (in_word),
        .cr_load      (cr_load),
        .cr_load_data (cr_load_data),
        .illegal      (illegal),
        .cr_view      (cr_view)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // mb[k] is mask bit k; rsv[7:1] -> word[12:6], rsv[0] -> word[0]
    function automatic logic [31:0] mkword(input logic [2:0] bf, input logic [2:0] bfa,
                                           input logic [2:0] bfb, input logic [3:0] mb,
                                           input logic [5:0] opc, input logic [4:0] xo,
                                           input logic [7:0] rsv);
        logic [31:0] w = '0;
        w[31:26] = opc;
        w[25:23] = bf;
        w[22]    = mb[0];
        w[21]    = mb[1];
        w[20:18] = bfa;
        w[17]    = mb[2];
        w[16]    = mb[3];
        w[15:13] = bfb;
        w[12:6]  = rsv[7:1];
        w[5:1]   = xo;
        w[0]     = rsv[0];
        return w;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] cr, input logic [2:0] bf,
                                          input logic [2:0] bfa, input logic [2:0] bfb,
                                          input logic [3:0] mb);
        logic [31:0] r = cr;
        for (int i = 0; i < 4; i++) begin
            int hi = cr[31 - 4*bf - i];
            int lo = cr[31 - 4*bfa - i];
            int j  = 2*hi + lo;
            if (mb[i]) r[31 - 4*bf - i] = cr[31 - 4*bfb - j];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, want);
        end
    endtask

    task automatic rnd_word(input logic [7:0] rsv, output logic [31:0] w,
                            output logic [2:0] bf, output logic [2:0] bfa,
                            output logic [2:0] bfb, output logic [3:0] mb);
        seed = nxt(seed);
        bf = seed[2:0]; bfa = seed[5:3]; bfb = seed[8:6]; mb = seed[12:9];
        w = mkword(bf, bfa, bfb, mb, seed[18:13], seed[23:19], rsv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [2:0]  bf, bfa, bfb;
        logic [3:0]  mb;

        rst = 1'b1; in_valid = 1'b0; in_word = '0; cr_load = 1'b0; cr_load_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cr", cr_view, 32'h0);
        chk("R1 illegal", {31'b0, illegal}, 32'h0);
        chk("R1 ready", {31'b0, in_ready}, 32'h0);
        rst = 1'b0;
        #1;
        chk("R8 ready", {31'b0, in_ready}, 32'h1);
        @(negedge clk);

        // exhaustive sweep of selectors and masks over random contents
        for (int bf_i = 0; bf_i < 8; bf_i++)
            for (int bfa_i = 0; bfa_i < 8; bfa_i++)
                for (int bfb_i = 0; bfb_i < 8; bfb_i++)
                    for (int m_i = 0; m_i < 16; m_i++) begin
                        seed = nxt(seed);
                        cr_load = 1'b1; cr_load_data = seed; in_valid = 1'b0;
                        #1;
                        if (m_i == 0) chk("R11 ready low", {31'b0, in_ready}, 32'h0);
                        @(negedge clk);
                        cr_load = 1'b0;
                        chk("R11 load", cr_view, cr_load_data);
                        exp_cr = model(cr_view, 3'(bf_i), 3'(bfa_i), 3'(bfb_i), 4'(m_i));
                        seed = nxt(seed);
                        in_word = mkword(3'(bf_i), 3'(bfa_i), 3'(bfb_i), 4'(m_i),
                                         seed[5:0], seed[10:6], 8'h0);
                        in_valid = 1'b1;
                        @(negedge clk);
                        in_valid = 1'b0;
                        chk("R2/R3/R4/R5/R6/R9 lookup", cr_view, exp_cr);
                    end

        // R8: back-to-back words, each result one cycle later
        seed = nxt(seed);
        cr_load = 1'b1; cr_load_data = seed;
        @(negedge clk);
        cr_load = 1'b0;
        exp_cr = cr_view;
        for (int k = 0; k < 40; k++) begin
            rnd_word(8'h0, w, bf, bfa, bfb, mb);
            in_word = w; in_valid = 1'b1;
            exp_cr = model(exp_cr, bf, bfa, bfb, mb);
            #1;
            chk("R8 ready", {31'b0, in_ready}, 32'h1);
            @(negedge clk);
            chk("R8 back-to-back", cr_view, exp_cr);
        end
        in_valid = 1'b0;

        // R7: each reserved bit alone blocks the write, flag lasts one cycle
        for (int b = 0; b < 8; b++) begin
            w = mkword(3'(b), 3'(7 - b), 3'(b + 3), 4'hF, 6'h1f, 5'h0b, 8'(1 << b));
            in_word = w; in_valid = 1'b1;
            exp_cr = cr_view;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R7 no write", cr_view, exp_cr);
            chk("R7 flag set", {31'b0, illegal}, 32'h1);
            @(negedge clk);
            chk("R7 flag clear", {31'b0, illegal}, 32'h0);
        end

        // R10: junk on the word bus with valid low
        exp_cr = cr_view;
        for (int k = 0; k < 8; k++) begin
            seed = nxt(seed);
            in_word = seed; in_valid = 1'b0;
            @(negedge clk);
            chk("R10 idle hold", cr_view, exp_cr);
        end

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset", cr_view, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule